// File: doc/BRIEF.md
# ALU Status Flag Generator

This block keeps the processor status word beside an ALU. Each cycle an ALU can offer it an operation class (add, subtract or a bitwise logic operation), the operand width (byte or word), both operands, the result and two carry bits. When the arithmetic update enable is high, the block derives six arithmetic flags from these inputs and registers them. It also holds three control flags that software drives. These are the string direction, the maskable interrupt enable and the single-step trap. Each control flag has its own set and clear strobes.

The whole status word is always visible as one 16-bit value so that it can be saved. A restore strobe loads every flag from a 16-bit word in one cycle, for example when a saved context is popped. The ALU datapath is outside the block. Its result and carry bits arrive as inputs.

Top module: `status_flag_unit`

## Requirements
- R1: After a synchronous reset the status word reads 16'h0000. Bits 1, 3, 5 and 12 to 15 always read 0.
- R2: The flag bit positions in the status word are: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11. Every flag change appears on `flags_out` on the clock edge that follows the request.
- R3: On an arithmetic update, zero is set exactly when the result is 0 within the operand width. Sign copies result bit 7 for byte operations and result bit 15 for word operations.
- R4: Operation encoding `op_kind`: 0 is add, 1 is subtract, 2 and 3 are logic. On an add or subtract update, carry takes `cy_msb`, which is the carry out of, or borrow into, the top bit of the operand width. On a logic update, carry is cleared and `cy_msb` is ignored.
- R5: On an add update, overflow is set when both operands have the same sign bit and the result sign differs from it. On a subtract update (a minus b), overflow is set when the operand sign bits differ and the result sign differs from a's sign bit. On a logic update, overflow is cleared.
- R6: On every arithmetic update, parity is set exactly when result bits 7:0 hold an even number of ones, for both byte and word operations.
- R7: On an add or subtract update, auxiliary carry takes `cy_nib`, which is the carry out of, or borrow into, bit 3. On a logic update, auxiliary carry is cleared.
- R8: While `arith_en` is low, the six arithmetic flags keep their values whatever the operand, result and carry inputs do.
- R9: Each control flag is set by its set strobe and cleared by its clear strobe. Clear wins when both are high. With neither strobe high, the flag holds. Control strobes never change the arithmetic flags, and arithmetic updates never change the control flags.
- R10: When `restore_en` is high, all nine flags load from the matching bits of `restore_word`. This overrides arithmetic updates and control strobes in the same cycle.
- R11: For byte operations, result bits 15:8 and operand bits 15:8 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arith_en | input | 1 | Update arithmetic flags this cycle |
| op_kind | input | 2 | Operation class: 0 add, 1 subtract, 2/3 logic |
| word_op | input | 1 | 1 for word width, 0 for byte width |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand (the subtrahend) |
| result | input | 16 | ALU result |
| cy_msb | input | 1 | Carry or borrow at the top bit of the width |
| cy_nib | input | 1 | Carry or borrow at bit 3 |
| dir_set | input | 1 | Set the direction flag |
| dir_clr | input | 1 | Clear the direction flag |
| ie_set | input | 1 | Set the interrupt enable flag |
| ie_clr | input | 1 | Clear the interrupt enable flag |
| trap_set | input | 1 | Set the trap flag |
| trap_clr | input | 1 | Clear the trap flag |
| restore_en | input | 1 | Load all flags from restore_word |
| restore_word | input | 16 | Saved status word to load |
| flags_out | output | 16 | Current status word |

## Verification
The block does not check its inputs against each other. The assertions therefore take for granted that `result`, `cy_msb` and `cy_nib` really come from the stated operands and operation class. The bench keeps to this by computing the result and both carry bits itself from the operands before it drives them, using plain integer arithmetic.

Where a requirement says an input is ignored, the bench drives deliberate junk into it. This covers the upper result and operand bytes in byte mode, the carry inputs during logic operations, and every ALU input while the update enable is low. The reference model then shows that the output does not move.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_CTL  = 3;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

    // index of each control flag inside the control vector
    localparam int CTL_TRAP = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_DIR  = 2;

    localparam logic [WORD_W-1:0] LIVE_MASK =
        WORD_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) | (1 << POS_ZF) |
                (1 << POS_SF) | (1 << POS_TF) | (1 << POS_IF) | (1 << POS_DF) |
                (1 << POS_OF));

    typedef enum logic [1:0] {
        OPK_ADD   = 2'd0,
        OPK_SUB   = 2'd1,
        OPK_LOGIC = 2'd2,
        OPK_LOGX  = 2'd3
    } opk_e;

    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } arith_flags_t;

    function automatic logic even_ones8(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input arith_flags_t a,
                                                      input logic [N_CTL-1:0] c);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[POS_CF] = a.cf_f;
        w[POS_PF] = a.pf_f;
        w[POS_AF] = a.af_f;
        w[POS_ZF] = a.zf_f;
        w[POS_SF] = a.sf_f;
        w[POS_OF] = a.of_f;
        w[POS_TF] = c[CTL_TRAP];
        w[POS_IF] = c[CTL_IE];
        w[POS_DF] = c[CTL_DIR];
        return w;
    endfunction

    function automatic arith_flags_t unpack_arith(input logic [WORD_W-1:0] w);
        arith_flags_t a;
        a.cf_f = w[POS_CF];
        a.pf_f = w[POS_PF];
        a.af_f = w[POS_AF];
        a.zf_f = w[POS_ZF];
        a.sf_f = w[POS_SF];
        a.of_f = w[POS_OF];
        return a;
    endfunction

endpackage

// File: rtl/flag_arith_calc.sv
module flag_arith_calc
    import flagu_pkg::*;
(
    input  opk_e                op,
    input  logic                word_op,
    input  logic [WORD_W-1:0]   a,
    input  logic [WORD_W-1:0]   b,
    input  logic [WORD_W-1:0]   res,
    input  logic                cy_msb,
    input  logic                cy_nib,
    output arith_flags_t        nxt
);

    logic sign_a;
    logic sign_b;
    logic sign_r;
    logic zero_r;
    logic is_logic;

    always_comb begin
        sign_a   = word_op ? a[WORD_W-1]   : a[BYTE_W-1];
        sign_b   = word_op ? b[WORD_W-1]   : b[BYTE_W-1];
        sign_r   = word_op ? res[WORD_W-1] : res[BYTE_W-1];
        zero_r   = word_op ? (res == '0)   : (res[BYTE_W-1:0] == '0);
        is_logic = (op == OPK_LOGIC) || (op == OPK_LOGX);

        nxt.zf_f = zero_r;
        nxt.sf_f = sign_r;
        nxt.pf_f = even_ones8(res[BYTE_W-1:0]);
        nxt.cf_f = is_logic ? 1'b0 : cy_msb;
        nxt.af_f = is_logic ? 1'b0 : cy_nib;
        unique case (op)
            OPK_ADD: nxt.of_f = (sign_a == sign_b) && (sign_r != sign_a);
            OPK_SUB: nxt.of_f = (sign_a != sign_b) && (sign_r != sign_a);
            default: nxt.of_f = 1'b0;
        endcase
    end

endmodule

// File: rtl/flag_ctrl_regs.sv
module flag_ctrl_regs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    input  logic         load_en,
    input  logic [N-1:0] load_v,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= 1'b0;
            else if (load_en)  q[i] <= load_v[i];
            else if (clr_v[i]) q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import flagu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arith_en,
    input  logic [1:0]  op_kind,
    input  logic        word_op,
    input  logic [15:0] opnd_a,
    input  logic [15:0] opnd_b,
    input  logic [15:0] result,
    input  logic        cy_msb,
    input  logic        cy_nib,
    input  logic        dir_set,
    input  logic        dir_clr,
    input  logic        ie_set,
    input  logic        ie_clr,
    input  logic        trap_set,
    input  logic        trap_clr,
    input  logic        restore_en,
    input  logic [15:0] restore_word,
    output logic [15:0] flags_out
);

    arith_flags_t      arith_q;
    arith_flags_t      arith_d;
    logic [N_CTL-1:0]  ctl_q;
    logic [N_CTL-1:0]  ctl_set;
    logic [N_CTL-1:0]  ctl_clr;
    logic [N_CTL-1:0]  ctl_load;

    flag_arith_calc u_calc (
        .op      (opk_e'(op_kind)),
        .word_op (word_op),
        .a       (opnd_a),
        .b       (opnd_b),
        .res     (result),
        .cy_msb  (cy_msb),
        .cy_nib  (cy_nib),
        .nxt     (arith_d)
    );

    always_comb begin
        ctl_set            = '0;
        ctl_clr            = '0;
        ctl_load           = '0;
        ctl_set[CTL_TRAP]  = trap_set;
        ctl_set[CTL_IE]    = ie_set;
        ctl_set[CTL_DIR]   = dir_set;
        ctl_clr[CTL_TRAP]  = trap_clr;
        ctl_clr[CTL_IE]    = ie_clr;
        ctl_clr[CTL_DIR]   = dir_clr;
        ctl_load[CTL_TRAP] = restore_word[POS_TF];
        ctl_load[CTL_IE]   = restore_word[POS_IF];
        ctl_load[CTL_DIR]  = restore_word[POS_DF];
    end

    flag_ctrl_regs #(.N(N_CTL)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .set_v   (ctl_set),
        .clr_v   (ctl_clr),
        .load_en (restore_en),
        .load_v  (ctl_load),
        .q       (ctl_q)
    );

    always_ff @(posedge clk) begin
        if (rst)             arith_q <= '0;
        else if (restore_en) arith_q <= unpack_arith(restore_word);
        else if (arith_en)   arith_q <= arith_d;
    end

    assign flags_out = pack_status(arith_q, ctl_q);

endmodule

// File: rtl/status_flag_unit_chk.sv
module status_flag_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        arith_en,
    input logic [1:0]  op_kind,
    input logic [15:0] result,
    input logic        word_op,
    input logic        dir_set,
    input logic        dir_clr,
    input logic        restore_en,
    input logic [15:0] restore_word,
    input logic [15:0] flags_out
);

    a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (flags_out & 16'hF02A) == 16'h0000);

    a_r6_parity_low_byte: assert property (@(posedge clk) disable iff (rst)
        (arith_en && !restore_en) |=> (flags_out[2] == ~^$past(result[7:0])));

    a_r4_logic_clears_carry: assert property (@(posedge clk) disable iff (rst)
        (arith_en && !restore_en && op_kind[1]) |=> (!flags_out[0] && !flags_out[11]));

    a_r3_sign_bit: assert property (@(posedge clk) disable iff (rst)
        (arith_en && !restore_en) |=>
            (flags_out[7] == ($past(word_op) ? $past(result[15]) : $past(result[7]))));

    a_r8_hold_arith: assert property (@(posedge clk) disable iff (rst)
        (!arith_en && !restore_en) |=> $stable(flags_out & 16'h08D5));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (dir_clr && !restore_en) |=> !flags_out[10]);

    a_r9_dir_set: assert property (@(posedge clk) disable iff (rst)
        (dir_set && !dir_clr && !restore_en) |=> flags_out[10]);

    a_r10_restore: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (flags_out == ($past(restore_word) & 16'h0FD5)));

endmodule

bind status_flag_unit status_flag_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .arith_en     (arith_en),
    .op_kind      (op_kind),
    .result       (result),
    .word_op      (word_op),
    .dir_set      (dir_set),
    .dir_clr      (dir_clr),
    .restore_en   (restore_en),
    .restore_word (restore_word),
    .flags_out    (flags_out)
);

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        arith_en;
    logic [1:0]  op_kind;
    logic        word_op;
    logic [15:0] opnd_a, opnd_b, result;
    logic        cy_msb, cy_nib;
    logic        dir_set, dir_clr, ie_set, ie_clr, trap_set, trap_clr;
    logic        restore_en;
    logic [15:0] restore_word;
    logic [15:0] flags_out;

    int total = 0;
    int bad   = 0;
    logic [15:0] model = 16'h0000;
    // true arithmetic flags of the current stimulus (from integer maths)
    bit t_cf, t_pf, t_af, t_zf, t_sf, t_of;

    always #2.5 clk = ~clk;

    status_flag_unit dut (
        .clk(clk), .rst(rst), .arith_en(arith_en), .op_kind(op_kind), .word_op(word_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .cy_msb(cy_msb), .cy_nib(cy_nib),
        .dir_set(dir_set), .dir_clr(dir_clr), .ie_set(ie_set), .ie_clr(ie_clr),
        .trap_set(trap_set), .trap_clr(trap_clr), .restore_en(restore_en),
        .restore_word(restore_word), .flags_out(flags_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        arith_en = 0; op_kind = 0; word_op = 0; opnd_a = 0; opnd_b = 0; result = 0;
        cy_msb = 0; cy_nib = 0; dir_set = 0; dir_clr = 0; ie_set = 0; ie_clr = 0;
        trap_set = 0; trap_clr = 0; restore_en = 0; restore_word = 0;
    endtask

    function automatic int to_signed(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Set up an ALU operation; result and carries computed here from integers.
    task automatic alu(input int kind, input bit wd, input int a, input int b, input bit en);
        int w, m, ra, rb, r, sa, sb, s, ones;
        w  = wd ? 16 : 8;
        m  = (1 << w) - 1;
        ra = a & m; rb = b & m;
        sa = to_signed(ra, w); sb = to_signed(rb, w);
        t_cf = 0; t_af = 0; t_of = 0;
        case (kind)
            0: begin
                r = (ra + rb) & m; t_cf = ((ra + rb) >> w) != 0;
                t_af = ((ra & 15) + (rb & 15)) > 15;
                s = sa + sb; t_of = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
            end
            1: begin
                r = (ra - rb) & m; t_cf = ra < rb; t_af = (ra & 15) < (rb & 15);
                s = sa - sb; t_of = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
            end
            2: r = ra ^ rb;
            default: r = ra | rb;
        endcase
        t_zf = (r == 0);
        t_sf = ((r >> (w - 1)) & 1) != 0;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        t_pf = (ones % 2) == 0;
        arith_en = en; op_kind = 2'(kind); word_op = wd;
        // R11: junk in the upper bytes of byte operations
        opnd_a = wd ? 16'(a) : {8'h5A, 8'(ra)};
        opnd_b = wd ? 16'(b) : {8'hC3, 8'(rb)};
        result = wd ? 16'(r) : {8'hA6, 8'(r)};
        // R4/R7: carry inputs are junk for logic operations
        cy_msb = (kind >= 2) ? 1'b1 : t_cf;
        cy_nib = (kind >= 2) ? 1'b1 : t_af;
    endtask

    // Advance one clock; model is updated from the requirements and compared.
    task automatic tick(input string ctx);
        logic [15:0] nx;
        nx = model;
        if (restore_en) nx = restore_word & 16'h0FD5;
        else begin
            if (arith_en) begin
                nx[0] = t_cf; nx[2] = t_pf; nx[4] = t_af;
                nx[6] = t_zf; nx[7] = t_sf; nx[11] = t_of;
            end
            if (trap_clr) nx[8] = 0; else if (trap_set) nx[8] = 1;
            if (ie_clr)   nx[9] = 0; else if (ie_set)   nx[9] = 1;
            if (dir_clr)  nx[10] = 0; else if (dir_set) nx[10] = 1;
        end
        @(posedge clk);
        @(negedge clk);
        model = nx;
        chk({ctx, " R4 carry"},     16'(flags_out[0]),  16'(model[0]));
        chk({ctx, " R6 parity"},    16'(flags_out[2]),  16'(model[2]));
        chk({ctx, " R7 aux"},       16'(flags_out[4]),  16'(model[4]));
        chk({ctx, " R3 zero/sign"}, 16'(flags_out[7:6]), 16'(model[7:6]));
        chk({ctx, " R5 overflow"},  16'(flags_out[11]), 16'(model[11]));
        chk({ctx, " R9 control"},   16'(flags_out[10:8]), 16'(model[10:8]));
        chk({ctx, " R1 unused"},    flags_out & 16'hF02A, 16'h0000);
        chk({ctx, " R2 word"},      flags_out, model);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 reset", flags_out, 16'h0000);

        alu(0, 0, 8'h7F, 8'h01, 1); tick("R5 byte add overflow");
        alu(0, 0, 8'hFF, 8'h01, 1); tick("R3 byte add zero carry");
        alu(0, 1, 16'h7FFF, 16'h0001, 1); tick("R5 word add overflow");
        alu(0, 1, 16'hFF00, 16'h0100, 1); tick("R3 word add zero");
        alu(1, 0, 8'h00, 8'h01, 1); tick("R4 byte borrow");
        alu(1, 0, 8'h80, 8'h01, 1); tick("R5 byte sub overflow");
        alu(1, 1, 16'h8000, 16'h0001, 1); tick("R5 word sub overflow");
        alu(1, 1, 16'h1234, 16'h1234, 1); tick("R3 word sub zero");
        alu(0, 1, 16'h0300, 16'h0000, 1); tick("R6 word parity low byte");
        alu(2, 0, 8'hF0, 8'h0F, 1); tick("R4 logic clears");
        alu(3, 1, 16'h8000, 16'h0001, 1); tick("R5 logic clears");
        alu(0, 0, 8'h08, 8'h08, 1); tick("R11 byte upper junk");
        alu(1, 0, 8'h00, 8'h01, 0); tick("R8 hold");
        alu(2, 1, 16'h0000, 16'h0000, 0); tick("R8 hold logic");
        idle();
        dir_set = 1; ie_set = 1; trap_set = 1; tick("R9 set all");
        idle(); dir_set = 1; dir_clr = 1; tick("R9 clear wins");
        idle(); ie_clr = 1; tick("R9 ie clear");
        alu(0, 1, 16'hFFFF, 16'h0001, 1); trap_clr = 1; tick("R9 mixed");
        idle(); restore_word = 16'hFFFF; restore_en = 1; tick("R10 restore ones");
        alu(0, 0, 8'h01, 8'h01, 1); dir_clr = 1; ie_clr = 1;
        restore_en = 1; restore_word = 16'h0400; tick("R10 restore override");
        idle(); restore_en = 1; restore_word = 16'h0000; tick("R10 restore zeros");

        for (int n = 0; n < 400; n++) begin
            alu($urandom_range(0, 3), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                1'($urandom_range(0, 3) != 0));
            dir_set  = 1'($urandom_range(0, 1)); dir_clr  = 1'($urandom_range(0, 3) == 0);
            ie_set   = 1'($urandom_range(0, 1)); ie_clr   = 1'($urandom_range(0, 3) == 0);
            trap_set = 1'($urandom_range(0, 1)); trap_clr = 1'($urandom_range(0, 3) == 0);
            restore_en   = 1'($urandom_range(0, 15) == 0);
            restore_word = 16'($urandom_range(0, 65535));
            tick("R2 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule